// File: doc/BRIEF.md
# Variable-Latency Integer ALU

This unit is a small integer ALU meant to sit behind scoreboard-style issue logic in an out-of-order core model. An operation arrives as an opcode and two operands under a valid/ready handshake. The unit then holds the operation for a fixed number of cycles chosen by the opcode's class. After that it offers the result under a second valid/ready handshake and keeps offering it until the consumer takes it.

Only one operation is in the unit at a time. Because each class has its own latency, several of these units working side by side finish in an order that differs from the issue order. That is the behaviour the surrounding read-release and write-release logic must cope with. Operands and opcode are registered when an operation is accepted, so the upstream buses are free to change from the next cycle on.

Top module: `vlat_alu`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is 1 only when the unit is idle, meaning no operation is counting down and no result is waiting. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1.
- R3: Opcodes 0 (add, `a+b`) and 1 (subtract, `a-b`) produce their result modulo 2^W. `out_valid` rises 2 clock edges after the accepting edge.
- R4: Opcode 2 (multiply) produces the low W bits of `a*b`. `out_valid` rises 5 edges after acceptance.
- R5: Opcode 3 (shift) produces `a` shifted left logically by the low log2(W) bits of `b`. `out_valid` rises 7 edges after acceptance.
- R6: Every opcode of 4 or more is a branch compare that takes 6 edges. Opcode bits [1:0] select the test: 00 equal, 01 not equal, 10 signed less-than, 11 unsigned less-than. The result is 1 when the test holds and 0 otherwise, placed in bit 0 with all other bits 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R8: On an edge where `out_valid` and `out_ready` are both 1, the result is transferred. In the next cycle `out_valid` is 0 and `in_ready` is 1.
- R9: The result depends only on the opcode and operands present at acceptance. Later changes on `in_op`, `in_a` and `in_b` have no effect on it.
- R10: `in_valid` raised while the unit is busy is ignored. No second operation is accepted until `in_ready` returns.
- R11: `out_data` is all zeros whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers an operation |
| in_ready | output | 1 | Unit idle and able to accept |
| in_op | input | OPW | Opcode |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Result, zero while no result is offered |

## Verification
The hardest situation to reach is a result stalled on the output side while the input side is still pushing. In that state `in_valid` stays high with fresh operands every cycle, and `out_ready` drops for several cycles. The transfer then has to hand over cleanly to a new acceptance exactly one cycle later. The bench gets there in two ways. Directed runs hold `in_valid` high across whole operations and withhold `out_ready`. A long random phase toggles both handshakes and rewrites the operand buses every cycle. A behavioural model checks all three outputs on every cycle, with no knowledge of the counter.

// File: rtl/vlat_alu_pkg.sv
package vlat_alu_pkg;

    typedef enum logic [1:0] {
        CLS_ARITH  = 2'd0,
        CLS_MUL    = 2'd1,
        CLS_SHIFT  = 2'd2,
        CLS_BRANCH = 2'd3
    } op_class_e;

    localparam int LAT_ARITH  = 2;
    localparam int LAT_MUL    = 5;
    localparam int LAT_SHIFT  = 7;
    localparam int LAT_BRANCH = 6;
    localparam int LAT_MAX    = 7;
    localparam int CNTW       = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] cnt;
        op_class_e       cls;
    } ctrl_state_s;

    function automatic logic [CNTW-1:0] latency_of(op_class_e c);
        logic [CNTW-1:0] r;
        case (c)
            CLS_MUL:    r = CNTW'(LAT_MUL);
            CLS_SHIFT:  r = CNTW'(LAT_SHIFT);
            CLS_BRANCH: r = CNTW'(LAT_BRANCH);
            default:    r = CNTW'(LAT_ARITH);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vlat_alu_decode.sv
module vlat_alu_decode
    import vlat_alu_pkg::*;
#(
    parameter int OPW = 3
) (
    input  logic [OPW-1:0] op,
    output op_class_e      cls
);
    localparam logic [OPW-1:0] OP_MUL   = OPW'(2);
    localparam logic [OPW-1:0] OP_SHIFT = OPW'(3);
    localparam logic [OPW-1:0] OP_BRMIN = OPW'(4);

    always_comb begin
        if (op >= OP_BRMIN)       cls = CLS_BRANCH;
        else if (op == OP_SHIFT)  cls = CLS_SHIFT;
        else if (op == OP_MUL)    cls = CLS_MUL;
        else                      cls = CLS_ARITH;
    end
endmodule

// File: rtl/vlat_alu_exec.sv
module vlat_alu_exec
    import vlat_alu_pkg::*;
#(
    parameter int W   = 16,
    parameter int OPW = 3
) (
    input  op_class_e      cls,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    localparam int SHW = (W > 1) ? $clog2(W) : 1;

    logic [SHW-1:0] shamt;
    logic [W-1:0]   sum_r;
    logic [W-1:0]   diff_r;
    logic [W-1:0]   prod_r;
    logic [W-1:0]   shl_r;
    logic           flag_r;

    generate
        if (W > 1) begin : g_shamt
            assign shamt = b[SHW-1:0];
        end else begin : g_shamt_one
            assign shamt = 1'b0;
        end
    endgenerate

    assign sum_r  = a + b;
    assign diff_r = a - b;
    assign prod_r = a * b;
    assign shl_r  = a << shamt;

    always_comb begin
        case (op[1:0])
            2'b00:   flag_r = (a == b);
            2'b01:   flag_r = (a != b);
            2'b10:   flag_r = ($signed(a) < $signed(b));
            default: flag_r = (a < b);
        endcase
    end

    always_comb begin
        case (cls)
            CLS_MUL:    res = prod_r;
            CLS_SHIFT:  res = shl_r;
            CLS_BRANCH: res = {{(W-1){1'b0}}, flag_r};
            default:    res = op[0] ? diff_r : sum_r;
        endcase
    end
endmodule

// File: rtl/vlat_alu_ctrl.sv
module vlat_alu_ctrl
    import vlat_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      out_ready,
    input  op_class_e cls_in,
    output logic      in_ready,
    output logic      out_valid,
    output logic      accept,
    output logic      load
);
    ctrl_state_s s_d, s_q;

    localparam logic [CNTW-1:0] CNT_ONE = CNTW'(1);

    always_comb begin
        s_d    = s_q;
        load   = 1'b0;
        accept = in_valid && !s_q.busy && !rst;
        if (s_q.busy) begin
            if (s_q.cnt == CNT_ONE) begin
                if (out_ready) begin
                    s_d.busy = 1'b0;
                    s_d.cnt  = '0;
                end
            end else if (s_q.cnt == '0) begin
                s_d.cnt = latency_of(cls_in);
                s_d.cls = cls_in;
                load    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_ONE;
            end
        end else if (accept) begin
            s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.busy <= 1'b0;
            s_q.cnt  <= '0;
            s_q.cls  <= CLS_ARITH;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = !s_q.busy;
    assign out_valid = s_q.busy && (s_q.cnt == CNT_ONE);

    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
    p_single_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
    p_lat_arith_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && s_q.cls == CLS_ARITH) |-> $past(accept, 3));
    p_lat_mul_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && s_q.cls == CLS_MUL) |-> $past(accept, 6));
    p_lat_shift_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && s_q.cls == CLS_SHIFT) |-> $past(accept, 8));
    p_lat_branch_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && s_q.cls == CLS_BRANCH) |-> $past(accept, 7));
endmodule

// File: rtl/vlat_alu.sv
module vlat_alu
    import vlat_alu_pkg::*;
#(
    parameter int W   = 16,
    parameter int OPW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [OPW-1:0] in_op,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W-1:0]   out_data
);
    typedef struct packed {
        logic [OPW-1:0] op;
        logic [W-1:0]   a;
        logic [W-1:0]   b;
    } capture_s;

    typedef struct packed {
        capture_s     cap;
        logic [W-1:0] res;
    } dp_state_s;

    dp_state_s dp_d, dp_q;
    op_class_e cls;
    logic      accept;
    logic      load;
    logic [W-1:0] exec_res;

    vlat_alu_decode #(.OPW(OPW)) u_decode (
        .op  (dp_q.cap.op),
        .cls (cls)
    );

    vlat_alu_exec #(.W(W), .OPW(OPW)) u_exec (
        .cls (cls),
        .op  (dp_q.cap.op),
        .a   (dp_q.cap.a),
        .b   (dp_q.cap.b),
        .res (exec_res)
    );

    vlat_alu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .cls_in    (cls),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .accept    (accept),
        .load      (load)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.cap.op = in_op;
            dp_d.cap.a  = in_a;
            dp_d.cap.b  = in_b;
        end
        if (load) begin
            dp_d.res = exec_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign out_data = out_valid ? dp_q.res : '0;

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_zero_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));
    p_capture_held_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(dp_q.cap));
endmodule

// File: tb/vlat_alu_test.sv
module vlat_alu_test;
    localparam int W   = 16;
    localparam int OPW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [OPW-1:0] in_op = '0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [W-1:0]   out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    vlat_alu #(.W(W), .OPW(OPW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    // behavioural reference
    bit           m_busy, m_valid, just_xfer, prev_stall, scramble, hold_valid;
    int           m_wait;
    int           m_op;
    logic [W-1:0] m_res;

    function automatic logic [W-1:0] ref_res(int op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = W'(a * b);
            3: r = a << (b % W);
            default: begin
                case (op % 4)
                    0: r = W'(a == b);
                    1: r = W'(a != b);
                    2: r = W'($signed(a) < $signed(b));
                    default: r = W'(a < b);
                endcase
            end
        endcase
        return r;
    endfunction

    function automatic int ref_lat(int op);
        if (op >= 4) return 6;
        if (op == 3) return 7;
        if (op == 2) return 5;
        return 2;
    endfunction

    function automatic string cls_tag(int op);
        if (op >= 4) return "R6";
        if (op == 3) return "R5";
        if (op == 2) return "R4";
        return "R3";
    endfunction

    always @(posedge clk) begin
        cycles     = cycles + 1;
        just_xfer  = 0;
        prev_stall = 0;
        if (rst) begin
            m_busy = 0; m_valid = 0; m_wait = 0; m_res = '0; m_op = 0;
        end else if (m_valid) begin
            if (out_ready) begin
                m_valid = 0; m_busy = 0; just_xfer = 1;
            end else begin
                prev_stall = 1;
            end
        end else if (m_busy) begin
            m_wait = m_wait - 1;
            if (m_wait == 0) m_valid = 1;
        end else if (in_valid) begin
            m_busy = 1;
            m_op   = int'(in_op);
            m_wait = ref_lat(m_op);
            m_res  = ref_res(m_op, in_a, in_b);
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            if (cycles > 0) begin
                check(in_ready == 1'b1, "R1", "in_ready in reset", W'(in_ready), W'(1));
                check(out_valid == 1'b0, "R1", "out_valid in reset", W'(out_valid), W'(0));
            end
        end else begin
            check(in_ready == !m_busy, (in_valid && m_busy) ? "R10" : "R2",
                  "in_ready", W'(in_ready), W'(!m_busy));
            check(out_valid == m_valid, just_xfer ? "R8" : cls_tag(m_op),
                  "out_valid", W'(out_valid), W'(m_valid));
            if (!m_valid)
                check(out_data == '0, "R11", "out_data idle", out_data, '0);
            else
                check(out_data == m_res,
                      prev_stall ? "R7" : (scramble ? "R9" : cls_tag(m_op)),
                      "out_data", out_data, m_res);
        end
    end

    task automatic send(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
        bit rdy;
        @(negedge clk);
        in_valid = 1; in_op = OPW'(op); in_a = a; in_b = b;
        forever begin
            rdy = in_ready;
            @(negedge clk);
            if (rdy) break;
        end
        if (!hold_valid) in_valid = 0;
        if (scramble) begin
            in_op = OPW'($urandom); in_a = W'($urandom); in_b = W'($urandom);
        end
    endtask

    task automatic drain(input int stall);
        repeat (stall) @(negedge clk);
        out_ready = 1;
        while (!(m_valid == 0 && m_busy == 0)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "after reset",
              W'({in_ready, out_valid}), W'(2'b10));

        // directed, one per class, consumer always ready (R3 R4 R5 R6)
        out_ready = 1;
        send(0, 16'hFFFF, 16'h0001); drain(0);
        send(1, 16'h0000, 16'h0001); drain(0);
        send(2, 16'h1234, 16'h5678); drain(0);
        send(3, 16'h8001, 16'h000F); drain(0);
        send(3, 16'h0003, 16'h0011); drain(0);
        send(4, 16'h00AA, 16'h00AA); drain(0);
        send(5, 16'h00AA, 16'h00AA); drain(0);
        send(6, 16'hFFFF, 16'h0001); drain(0);
        send(7, 16'hFFFF, 16'h0001); drain(0);

        // stalled consumer (R7) and handover after transfer (R8)
        out_ready = 0;
        send(2, 16'h00FF, 16'h0101); drain(12);
        out_ready = 0;
        send(4, 16'h0001, 16'h0002); drain(4);

        // upstream keeps pushing with changing operands (R9, R10)
        scramble = 1; hold_valid = 1; out_ready = 0;
        send(3, 16'h00F0, 16'h0004);
        repeat (15) begin
            @(negedge clk);
            in_op = OPW'($urandom); in_a = W'($urandom); in_b = W'($urandom);
        end
        out_ready = 1;
        repeat (30) begin
            @(negedge clk);
            in_op = OPW'($urandom); in_a = W'($urandom); in_b = W'($urandom);
        end
        hold_valid = 0;

        // random handshakes on both sides
        repeat (600) begin
            @(negedge clk);
            in_valid  = ($urandom % 2) == 0;
            in_op     = OPW'($urandom);
            in_a      = ($urandom % 4 == 0) ? W'(16'h8000) : W'($urandom);
            in_b      = ($urandom % 4 == 0) ? in_a : W'($urandom);
            out_ready = ($urandom % 3) != 0;
        end
        in_valid = 0; out_ready = 1;
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule